// File: doc/BRIEF.md
# Blit Command Stream Validator

This block sits in front of a 2D drawing engine and inspects each register-write command before it is let through. A command is a pair of 32-bit words: an offset word that selects the engine register, and a value word. The validator keeps a small descriptor for the source buffer and for the destination buffer. Each descriptor holds the line pitch in bytes, the pixel format code and the two corner points. Descriptor fields are captured from the commands as they arrive.

When the base-address command of the source or destination buffer arrives, the validator checks that buffer. The rectangle width and height must lie in range. The last byte the engine would touch, computed from the captured fields and the format's bytes per pixel, must fall inside the buffer size on the matching size input. Base-address commands also carry a buffer-kind flag in the top bit of the offset word. The validator reports that flag and strips it from the forwarded word. The first failure is latched with an error code, and the validator then accepts nothing more until it is reset.

The controller runs six named states. IDLE accepts a command (transition *accept*). DECODE classifies the offset and goes to FAIL when the offset is out of the window (*reject*), to CHECK for a source or destination base address (*bound*), and to PASS otherwise (*forward*). CHECK goes to PASS (*in_bounds*) or to FAIL (*violation*). PASS returns to IDLE (*done*). FAIL moves to LOCK (*latch*). LOCK is left only by reset.

Top module: `blit_cmd_validator`

## Requirements
- R1: Only bits [11:0] of the offset word form the register offset. A command whose offset is below 0x104 or above 0x880 fails with error code 1. The bounds themselves are accepted.
- R2: A base-address command (offsets 0x304, 0x318, 0x404, 0x418, 0x500, 0x520) with offset bit 31 set reports `out_user`=1 and forwards the word with bit 31 cleared. With bit 31 clear, it reports 0 and forwards the word unchanged. On any other command `out_user` is 0 and the word is forwarded unchanged.
- R3: The bytes per pixel come from value bits [3:0] of the mode command (0x30C source, 0x40C destination). Codes 0–1 give 4, codes 2–6 give 2, code 7 gives 3, and every other code gives 1.
- R4: A pitch command (0x308/0x408) stores the full value word. A corner command stores x from bits [12:0] and y from bits [28:16]; left-top is at 0x310/0x410 and right-bottom at 0x314/0x414.
- R5: On a source or destination base-address command, width = right − left, taken as a signed value, must be in 1..8000, otherwise the command fails with code 2.
- R6: Height = bottom − top, taken as a signed value, must be in 1..8000, otherwise the command fails with code 3. The width check takes priority over the height check.
- R7: The last byte is (bottom − 1) × pitch + right × bpp − 1, computed without overflow. If it is greater than or equal to the size input (`src_size` or `dst_size`), the command fails with code 4. Otherwise it passes.
- R8: The plane-2, pattern and mask base addresses, and all other in-window offsets, pass without a bounds check.
- R9: After a failure, `err_code` holds the first code and `cmd_ready` stays low until reset. Commands presented in that period get no response.
- R10: Each accepted command produces exactly one single-cycle `res_valid`, with exactly one of `res_pass` and `res_fail` set. `cmd_ready` is low from acceptance until the response has been given.
- R11: After reset `cmd_ready` is 1, `res_valid` is 0, `err_code` is 0, and both descriptors are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset; clears the latched error and the descriptors |
| cmd_valid | input | 1 | A command is presented |
| cmd_ready | output | 1 | The validator is idle and takes the command |
| cmd_offset | input | 32 | Offset word; bit 31 is the buffer-kind flag on base-address commands |
| cmd_value | input | 32 | Value word |
| src_size | input | 32 | Byte size of the source buffer |
| dst_size | input | 32 | Byte size of the destination buffer |
| res_valid | output | 1 | One-cycle verdict for the accepted command |
| res_pass | output | 1 | The command is allowed |
| res_fail | output | 1 | The command is rejected |
| err_code | output | 3 | Latched first error: 0 none, 1 window, 2 width, 3 height, 4 overrun |
| out_word | output | 32 | Forwarded offset word, with the flag bit stripped on a base address |
| out_user | output | 1 | The base address is a user-pointer buffer |

## Verification
The assertions take for granted that `src_size` and `dst_size` hold steady from the acceptance of a base-address command until its verdict. They also take for granted that reset is applied before the first command. The bench changes the size inputs only while the validator is idle, and it sends a new command only after the previous verdict, or while the block is locked. Random descriptors are drawn near the 8000 limits and near zero, and each buffer size is set to the computed last byte, one past it, or a random value. This exercises both sides of every comparison.

// File: rtl/blit_val_pkg.sv
package blit_val_pkg;

    localparam int CMD_W   = 32;
    localparam int OFF_W   = 12;
    localparam int COORD_W = 13;
    localparam int FMT_W   = 4;

    localparam logic [OFF_W-1:0] WIN_LO   = 12'h104;
    localparam logic [OFF_W-1:0] WIN_HI   = 12'h880;
    localparam logic [3:0]       GRP_SRC  = 4'h3;
    localparam logic [3:0]       GRP_DST  = 4'h4;
    localparam logic [7:0]       SUB_BASE = 8'h04;
    localparam logic [7:0]       SUB_PTCH = 8'h08;
    localparam logic [7:0]       SUB_MODE = 8'h0C;
    localparam logic [7:0]       SUB_LT   = 8'h10;
    localparam logic [7:0]       SUB_RB   = 8'h14;
    localparam logic [7:0]       SUB_PL2  = 8'h18;
    localparam logic [OFF_W-1:0] OFF_PATT = 12'h500;
    localparam logic [OFF_W-1:0] OFF_MASK = 12'h520;

    typedef enum logic [2:0] {
        ERR_NONE    = 3'd0,
        ERR_WINDOW  = 3'd1,
        ERR_WIDTH   = 3'd2,
        ERR_HEIGHT  = 3'd3,
        ERR_OVERRUN = 3'd4
    } err_e;

    typedef enum logic [2:0] {
        RC_OTHER,
        RC_PITCH,
        RC_MODE,
        RC_LT,
        RC_RB,
        RC_BASE_CHK,
        RC_BASE_FREE
    } reg_cls_e;

    typedef struct packed {
        logic [CMD_W-1:0]   pitch;
        logic [FMT_W-1:0]   fmt;
        logic [COORD_W-1:0] lx;
        logic [COORD_W-1:0] ty;
        logic [COORD_W-1:0] rx;
        logic [COORD_W-1:0] by;
    } desc_t;

    function automatic logic [2:0] fmt_bytes(input logic [FMT_W-1:0] f);
        if (f <= 4'd1)      return 3'd4;
        else if (f <= 4'd6) return 3'd2;
        else if (f == 4'd7) return 3'd3;
        else                return 3'd1;
    endfunction

endpackage

// File: rtl/blit_val_decode.sv
module blit_val_decode
    import blit_val_pkg::*;
(
    input  logic [OFF_W-1:0] off,
    output logic             in_win,
    output reg_cls_e         cls,
    output logic             is_dst
);
    logic grp_src, grp_dst;

    always_comb begin
        in_win  = (off >= WIN_LO) && (off <= WIN_HI);
        grp_src = (off[11:8] == GRP_SRC);
        grp_dst = (off[11:8] == GRP_DST);
        is_dst  = grp_dst;
        cls     = RC_OTHER;
        if (grp_src || grp_dst) begin
            case (off[7:0])
                SUB_BASE: cls = RC_BASE_CHK;
                SUB_PTCH: cls = RC_PITCH;
                SUB_MODE: cls = RC_MODE;
                SUB_LT:   cls = RC_LT;
                SUB_RB:   cls = RC_RB;
                SUB_PL2:  cls = RC_BASE_FREE;
                default:  cls = RC_OTHER;
            endcase
        end else if (off == OFF_PATT || off == OFF_MASK) begin
            cls = RC_BASE_FREE;
        end
    end
endmodule

// File: rtl/blit_val_desc_bank.sv
module blit_val_desc_bank
    import blit_val_pkg::*;
#(
    parameter int NBUF = 2,
    localparam int SELW = (NBUF > 1) ? $clog2(NBUF) : 1
)(
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 we,
    input  logic [SELW-1:0]      sel,
    input  reg_cls_e             cls,
    input  logic [CMD_W-1:0]     value,
    output desc_t [NBUF-1:0]     descs
);
    for (genvar g = 0; g < NBUF; g++) begin : g_buf
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                descs[g] <= '0;
            end else if (we && sel == SELW'(g)) begin
                case (cls)
                    RC_PITCH: descs[g].pitch <= value;
                    RC_MODE:  descs[g].fmt   <= value[FMT_W-1:0];
                    RC_LT: begin
                        descs[g].lx <= value[COORD_W-1:0];
                        descs[g].ty <= value[16+COORD_W-1:16];
                    end
                    RC_RB: begin
                        descs[g].rx <= value[COORD_W-1:0];
                        descs[g].by <= value[16+COORD_W-1:16];
                    end
                    default: ;
                endcase
            end
        end
    end
endmodule

// File: rtl/blit_val_bounds.sv
module blit_val_bounds
    import blit_val_pkg::*;
#(
    parameter int LEN_MAX = 8000,
    parameter int SIZE_W  = 32,
    parameter int ACC_W   = 48
)(
    input  desc_t             d,
    input  logic [SIZE_W-1:0] size,
    output err_e              code
);
    localparam int SDW = COORD_W + 1;

    logic signed [SDW-1:0] width, height;
    logic [ACC_W-1:0]      last_byte;
    logic [2:0]            bpp;

    always_comb begin
        width     = $signed({1'b0, d.rx}) - $signed({1'b0, d.lx});
        height    = $signed({1'b0, d.by}) - $signed({1'b0, d.ty});
        bpp       = fmt_bytes(d.fmt);
        last_byte = (ACC_W'(d.by) - ACC_W'(1)) * ACC_W'(d.pitch)
                  + ACC_W'(d.rx) * ACC_W'(bpp) - ACC_W'(1);
        if (int'(width) < 1 || int'(width) > LEN_MAX)
            code = ERR_WIDTH;
        else if (int'(height) < 1 || int'(height) > LEN_MAX)
            code = ERR_HEIGHT;
        else if (last_byte >= ACC_W'(size))
            code = ERR_OVERRUN;
        else
            code = ERR_NONE;
    end
endmodule

// File: rtl/blit_cmd_validator.sv
module blit_cmd_validator
    import blit_val_pkg::*;
#(
    parameter int LEN_MAX = 8000,
    parameter int SIZE_W  = 32,
    parameter int ACC_W   = 48
)(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmd_valid,
    output logic              cmd_ready,
    input  logic [CMD_W-1:0]  cmd_offset,
    input  logic [CMD_W-1:0]  cmd_value,
    input  logic [SIZE_W-1:0] src_size,
    input  logic [SIZE_W-1:0] dst_size,
    output logic              res_valid,
    output logic              res_pass,
    output logic              res_fail,
    output logic [2:0]        err_code,
    output logic [CMD_W-1:0]  out_word,
    output logic              out_user
);
    localparam int NBUF = 2;

    typedef enum logic [2:0] {
        S_IDLE, S_DECODE, S_CHECK, S_PASS, S_FAIL, S_LOCK
    } state_e;

    state_e           st, nxt;
    err_e             code_nxt, err_q, bnd_code;
    logic [CMD_W-1:0] word_q, value_q;
    logic             user_q, sel_q;
    logic             in_win, dec_dst, desc_we;
    reg_cls_e         cls;
    desc_t [NBUF-1:0] descs;
    desc_t            chk_desc;
    logic [SIZE_W-1:0] chk_size;

    blit_val_decode u_decode (
        .off    (word_q[OFF_W-1:0]),
        .in_win (in_win),
        .cls    (cls),
        .is_dst (dec_dst)
    );

    assign desc_we = (st == S_DECODE) && in_win &&
                     (cls == RC_PITCH || cls == RC_MODE || cls == RC_LT || cls == RC_RB);

    blit_val_desc_bank #(.NBUF(NBUF)) u_bank (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (desc_we),
        .sel   (dec_dst),
        .cls   (cls),
        .value (value_q),
        .descs (descs)
    );

    assign chk_desc = descs[sel_q];
    assign chk_size = sel_q ? dst_size : src_size;

    blit_val_bounds #(.LEN_MAX(LEN_MAX), .SIZE_W(SIZE_W), .ACC_W(ACC_W)) u_bounds (
        .d    (chk_desc),
        .size (chk_size),
        .code (bnd_code)
    );

    // next-state logic
    always_comb begin
        nxt      = st;
        code_nxt = ERR_NONE;
        unique case (st)
            S_IDLE:   if (cmd_valid) nxt = S_DECODE;
            S_DECODE: begin
                if (!in_win) begin
                    nxt      = S_FAIL;
                    code_nxt = ERR_WINDOW;
                end else if (cls == RC_BASE_CHK) begin
                    nxt = S_CHECK;
                end else begin
                    nxt = S_PASS;
                end
            end
            S_CHECK: begin
                if (bnd_code != ERR_NONE) begin
                    nxt      = S_FAIL;
                    code_nxt = bnd_code;
                end else begin
                    nxt = S_PASS;
                end
            end
            S_PASS:   nxt = S_IDLE;
            S_FAIL:   nxt = S_LOCK;
            S_LOCK:   nxt = S_LOCK;
            default:  nxt = S_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st <= S_IDLE;
        else        st <= nxt;
    end

    // captured command and latched error
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            word_q  <= '0;
            value_q <= '0;
            user_q  <= 1'b0;
            sel_q   <= 1'b0;
            err_q   <= ERR_NONE;
        end else begin
            if (st == S_IDLE && cmd_valid) begin
                word_q  <= cmd_offset;
                value_q <= cmd_value;
            end
            if (st == S_DECODE) begin
                user_q <= in_win && word_q[CMD_W-1] &&
                          (cls == RC_BASE_CHK || cls == RC_BASE_FREE);
                sel_q  <= dec_dst;
            end
            if (nxt == S_FAIL && st != S_FAIL)
                err_q <= code_nxt;
        end
    end

    // outputs
    always_comb begin
        cmd_ready = 1'b0;
        res_valid = 1'b0;
        res_pass  = 1'b0;
        res_fail  = 1'b0;
        unique case (st)
            S_IDLE: cmd_ready = 1'b1;
            S_PASS: begin
                res_valid = 1'b1;
                res_pass  = 1'b1;
            end
            S_FAIL: begin
                res_valid = 1'b1;
                res_fail  = 1'b1;
            end
            default: ;
        endcase
        err_code = err_q;
        out_user = user_q;
        out_word = user_q ? {1'b0, word_q[CMD_W-2:0]} : word_q;
    end

    p_err_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (err_code != 3'd0) |=> $stable(err_code));
    p_lock_ready_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (err_code != 3'd0) |-> !cmd_ready);
    p_fail_code_r9: assert property (@(posedge clk) disable iff (!rst_n)
        res_fail |-> (err_code != 3'd0));
    p_single_resp_r10: assert property (@(posedge clk) disable iff (!rst_n)
        res_valid |=> !res_valid);
    p_verdict_excl_r10: assert property (@(posedge clk) disable iff (!rst_n)
        res_valid |-> (res_pass != res_fail));
    p_busy_after_accept_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && cmd_ready) |=> !cmd_ready);
    p_flag_strip_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (res_valid && out_user) |-> !out_word[CMD_W-1]);
    p_pass_clean_r7: assert property (@(posedge clk) disable iff (!rst_n)
        res_pass |-> (err_code == 3'd0));

endmodule

// File: tb/blit_cmd_validator_tb.sv
`timescale 1ns/1ps
module blit_cmd_validator_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cmd_valid = 1'b0;
    logic        cmd_ready;
    logic [31:0] cmd_offset = '0;
    logic [31:0] cmd_value = '0;
    logic [31:0] src_size = '0;
    logic [31:0] dst_size = '0;
    logic        res_valid, res_pass, res_fail, out_user;
    logic [2:0]  err_code;
    logic [31:0] out_word;

    int n_chk = 0;
    int n_bad = 0;

    longint sh_pitch[2];
    int     sh_fmt[2];
    logic [31:0] sh_lt[2];
    logic [31:0] sh_rb[2];

    always #2.5 clk = ~clk;

    blit_cmd_validator dut_i (
        .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
        .cmd_offset(cmd_offset), .cmd_value(cmd_value), .src_size(src_size),
        .dst_size(dst_size), .res_valid(res_valid), .res_pass(res_pass),
        .res_fail(res_fail), .err_code(err_code), .out_word(out_word),
        .out_user(out_user)
    );

    task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
        end
    endtask

    function automatic int tb_bpp(input int f);
        case (f)
            0, 1:          return 4;
            2, 3, 4, 5, 6: return 2;
            7:             return 3;
            default:       return 1;
        endcase
    endfunction

    function automatic longint tb_last(input int s);
        longint rx, by;
        rx = longint'(sh_rb[s][12:0]);
        by = longint'(sh_rb[s][28:16]);
        return (by - 1) * sh_pitch[s] + rx * tb_bpp(sh_fmt[s]) - 1;
    endfunction

    function automatic int tb_eval(input int s);
        int w, h;
        w = int'(sh_rb[s][12:0]) - int'(sh_lt[s][12:0]);
        h = int'(sh_rb[s][28:16]) - int'(sh_lt[s][28:16]);
        if (w < 1 || w > 8000) return 2;
        if (h < 1 || h > 8000) return 3;
        if (tb_last(s) >= longint'(s == 1 ? dst_size : src_size)) return 4;
        return 0;
    endfunction

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        cmd_valid = 1'b0;
        for (int i = 0; i < 2; i++) begin
            sh_pitch[i] = 0; sh_fmt[i] = 0; sh_lt[i] = '0; sh_rb[i] = '0;
        end
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    // send one command and compare the verdict with the model
    task automatic wr(input logic [31:0] w, input logic [31:0] v, input string tag);
        logic [11:0] off;
        int s, exp_code;
        bit is_base, exp_user, got;
        logic [31:0] exp_word;
        off = w[11:0];
        s = (off[11:8] == 4'h4) ? 1 : 0;
        exp_code = 0;
        is_base = (off == 12'h304 || off == 12'h318 || off == 12'h404 ||
                   off == 12'h418 || off == 12'h500 || off == 12'h520);
        if (off < 12'h104 || off > 12'h880) begin
            exp_code = 1;
            is_base = 1'b0;
        end else if (off[11:8] == 4'h3 || off[11:8] == 4'h4) begin
            case (off[7:0])
                8'h08: sh_pitch[s] = longint'(v);
                8'h0C: sh_fmt[s] = int'(v[3:0]);
                8'h10: sh_lt[s] = v;
                8'h14: sh_rb[s] = v;
                8'h04: exp_code = tb_eval(s);
                default: ;
            endcase
        end
        exp_user = is_base && w[31];
        exp_word = exp_user ? (w & 32'h7FFF_FFFF) : w;
        cmd_offset = w;
        cmd_value = v;
        cmd_valid = 1'b1;
        @(posedge clk);
        @(negedge clk);
        cmd_valid = 1'b0;
        got = 1'b0;
        for (int i = 0; i < 8 && !got; i++) begin
            if (res_valid) begin
                got = 1'b1;
                chk(res_fail == (exp_code != 0) && res_pass == (exp_code == 0),
                    {tag, " verdict"}, longint'({res_pass, res_fail}), exp_code);
                chk(int'(err_code) == exp_code, {tag, " code"}, err_code, exp_code);
                chk(out_word == exp_word && out_user == exp_user, {tag, " word/flag"},
                    longint'({out_user, out_word}), longint'({exp_user, exp_word}));
                @(negedge clk);
                chk(!res_valid, "R10 single pulse", res_valid, 0);
            end else begin
                @(negedge clk);
            end
        end
        chk(got, {tag, " R10 response"}, got, 1);
    endtask

    initial begin
        #(5.0 * 190000);
        n_bad++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_bad);
        $finish;
    end

    initial begin
        do_reset();
        // R11 reset state
        chk(cmd_ready == 1'b1, "R11 ready", cmd_ready, 1);
        chk(res_valid == 1'b0, "R11 res_valid", res_valid, 0);
        chk(err_code == 3'd0, "R11 err_code", err_code, 0);

        // R11 / R5: zero descriptor fails the width check
        src_size = 32'hFFFF_FFFF;
        wr(32'h0000_0304, 0, "R5 zero desc");

        // R1 window edges
        do_reset(); wr(32'h0000_0104, 5, "R1 low edge");
        wr(32'h0000_0880, 5, "R1 high edge");
        wr(32'hFFFF_F104, 5, "R1 upper bits ignored");
        wr(32'h0000_0103, 5, "R1 below");
        do_reset(); wr(32'h0000_0881, 5, "R1 above");

        // R9 lock: no response, ready low, code held
        @(negedge clk);
        cmd_offset = 32'h0000_0200; cmd_valid = 1'b1;
        for (int i = 0; i < 5; i++) begin
            @(negedge clk);
            chk(!cmd_ready && !res_valid, "R9 locked quiet", {cmd_ready, res_valid}, 0);
            chk(err_code == 3'd1, "R9 code held", err_code, 1);
        end
        cmd_valid = 1'b0;

        // R2 / R4 / R8: flag handling and unchecked bases
        do_reset();
        src_size = 32'd1000;
        wr(32'h8000_0308, 32'd100, "R2 flag on pitch kept");
        wr(32'h0000_0310, 32'h0002_0003, "R4 left-top");
        wr(32'h0000_0314, 32'h0004_0008, "R4 right-bottom");
        wr(32'h8000_0304, 32'h1234, "R2 user base");
        wr(32'h0000_0304, 32'h1234, "R2 object base");
        wr(32'h8000_0500, 0, "R8 pattern base");
        wr(32'h0000_0520, 0, "R8 mask base");
        wr(32'h8000_0418, 0, "R8 dst plane2");
        wr(32'h0000_0318, 0, "R8 src plane2");
        // last = 3*100 + 8*4 - 1 = 331: size 331 overruns
        src_size = 32'd331;
        wr(32'h0000_0304, 0, "R7 size equals last byte");

        // R3: every format code at the exact boundary
        for (int f = 0; f < 16; f++) begin
            for (int k = 0; k < 2; k++) begin
                do_reset();
                dst_size = 32'(10 * tb_bpp(f) - k);
                wr(32'h0000_0408, 32'd0, "R4 pitch");
                wr(32'h0000_040C, 32'(f) | 32'hABC0, "R3 mode");
                wr(32'h0000_0410, 32'h0000_0000, "R4 lt");
                wr(32'h0000_0414, 32'h0001_000A, "R4 rb");
                wr(32'h0000_0404, 0, "R3 bpp boundary");
            end
        end

        // R5 / R6 limits and priority
        do_reset(); dst_size = 32'hFFFF_FFFF;
        wr(32'h0000_0414, {3'b0, 13'd1, 3'b0, 13'd8000}, "R4 rb");
        wr(32'h0000_0404, 0, "R5 width 8000 ok");
        wr(32'h0000_0414, {3'b0, 13'd8000, 3'b0, 13'd8000}, "R4 rb");
        wr(32'h0000_0404, 0, "R6 height 8000 ok");
        wr(32'h0000_0414, {3'b0, 13'd8001, 3'b0, 13'd8001}, "R4 rb");
        wr(32'h0000_0404, 0, "R6 width before height");
        do_reset(); dst_size = 32'hFFFF_FFFF;
        wr(32'h0000_0410, 32'h0005_0000, "R4 lt");
        wr(32'h0000_0414, 32'h0005_0004, "R4 rb");
        wr(32'h0000_0404, 0, "R6 height zero");
        do_reset(); src_size = 32'hFFFF_FFFF;
        wr(32'h0000_0310, 32'h0000_0009, "R4 lt");
        wr(32'h0000_0314, 32'h0003_0004, "R4 rb");
        wr(32'h0000_0304, 0, "R5 negative width");

        // random mix
        void'($urandom(32'd777));
        for (int it = 0; it < 150; it++) begin
            int s, lx, ty, rx, by, fmt;
            logic [11:0] grp;
            logic [31:0] pitch, sz;
            longint last;
            do_reset();
            s = int'($urandom % 2);
            grp = (s == 1) ? 12'h400 : 12'h300;
            lx = int'($urandom % 64); ty = int'($urandom % 64);
            rx = ($urandom % 6 == 0) ? lx + 7995 + int'($urandom % 10) : lx + int'($urandom % 100) - 5;
            by = ($urandom % 6 == 0) ? ty + 7995 + int'($urandom % 10) : ty + int'($urandom % 100) - 5;
            if (rx < 0) rx = 0;
            if (by < 0) by = 0;
            rx = rx & 8191; by = by & 8191;
            pitch = $urandom % 5000;
            fmt = int'($urandom % 16);
            wr({20'h0, grp | 12'h008}, pitch, "R4 rnd pitch");
            wr({20'h0, grp | 12'h00C}, ($urandom & 32'hFFFF_FFF0) | 32'(fmt), "R3 rnd mode");
            wr({20'h0, grp | 12'h010}, ($urandom & 32'hE000_E000) | 32'(ty << 16) | 32'(lx), "R4 rnd lt");
            wr({20'h0, grp | 12'h014}, ($urandom & 32'hE000_E000) | 32'(by << 16) | 32'(rx), "R4 rnd rb");
            last = tb_last(s);
            case ($urandom % 3)
                0: sz = (last + 1 > 64'hFFFF_FFFF || last < 0) ? $urandom : 32'(last + 1);
                1: sz = (last > 64'hFFFF_FFFF || last < 0) ? $urandom : 32'(last);
                default: sz = $urandom;
            endcase
            if (s == 1) begin dst_size = sz; src_size = $urandom; end
            else        begin src_size = sz; dst_size = $urandom; end
            if (it % 10 == 0)
                wr(($urandom & 32'hFFFF_F000) | 32'($urandom % 12'h104), 0, "R1 rnd out of window");
            else
                wr({$urandom % 2 == 1 ? 1'b1 : 1'b0, 19'h0, grp | 12'h004}, $urandom, "R7 rnd base");
        end

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_bad);
        $finish;
    end

endmodule